// File: doc/BRIEF.md
# Interrupt Mode CSR Unit

This unit holds the machine-level control registers that a hart needs in order to run either a legacy interrupt scheme or a level-based interrupt controller scheme. It stores the trap-vector register, the vector-table base register, the cause register with its extended context fields, a status register with the previous-privilege and enable fields, the legacy enable and pending registers, the active interrupt level and the level threshold. The active mode is taken from the encoding of the trap-vector register. Several read views depend on that mode: legacy registers disappear, and the cause register shows context fields that are otherwise hidden.

A core reaches the registers through a simple select/write port. Read data comes back one cycle after the access. Trap entry and trap return each have a one-cycle strobe. The unit updates its saved context and levels from these strobes and lowers the threshold when a return drops privilege. The effective level, which is the larger of the active level and the threshold, is presented as a combinational output for the arbitration logic that sits outside this unit.

Top module: `irq_mode_csr_unit`

## Requirements
- R1: The controller mode output is 1 exactly when trap-vector bits [1:0] are 2'b11 and bits [5:2] are 4'b0000. Any other value selects legacy mode. The trap-vector register (select 0) reads back as written. The vector base output is bits [XLEN-1:6] of that register with six zero bits below.
- R2: The vector-table base register (select 1) keeps bits [XLEN-1:6] of a write. Its bits [5:0] always read as zero, and it is presented on the table base output.
- R3: In controller mode the legacy enable register (select 4) and legacy pending register (select 5) read as zero, and writes to them are ignored. Their stored low LEG_W bits are kept and read back again once legacy mode returns.
- R4: Status (select 3) holds the global enable at bit 3, the previous enable at bit 7 and the previous privilege at bits [12:11]. In controller mode, cause (select 2) bits [29:28] and bit 27 mirror the status previous privilege and previous enable, and a cause write updates them. In legacy mode these cause bits read as zero. Cause bit XLEN-1 is the interrupt flag and bits [11:0] are the code.
- R5: Cause bits [23:16] hold the previous level. In legacy mode they read as zero and cannot be written. A trap-vector write that leaves controller mode clears the stored previous level.
- R6: The threshold register (select 7) holds an 8-bit level in bits [7:0], and a write is visible on the next read. The effective level output always equals the maximum of the active level and the threshold.
- R7: A return strobe whose stored previous privilege is numerically below the current privilege sets the threshold to 0. A return that does not lower privilege leaves the threshold unchanged.
- R8: After reset every register reads as zero, the unit is in legacy mode, and the active level, previous level and effective level are 0.
- R9: A trap strobe loads the code and interrupt flag, copies the current privilege into previous privilege, copies the global enable into previous enable, and clears the global enable. For an interrupt in controller mode it also saves the active level as previous level and loads the trap level as the active level.
- R10: A return strobe sets the global enable from previous enable, sets previous enable to 1 and previous privilege to 0. In controller mode it also restores the active level from the previous level.
- R11: A read returns data on csr_rdata one cycle after the access. The active level register (select 6) is read-only: a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | Register access strobe |
| csr_we | input | 1 | Access is a write |
| csr_sel | input | 3 | Register select (0..7) |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| trap_valid | input | 1 | Trap entry strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | 12 | Trap code |
| trap_level | input | 8 | Level of the interrupt being taken |
| ret_valid | input | 1 | Trap return strobe |
| ctl_mode | output | 1 | Level-based controller mode active |
| vec_base | output | XLEN | Aligned trap-vector base |
| tbl_base | output | XLEN | Aligned vector-table base |
| eff_level | output | 8 | max(active level, threshold) |

## Verification
The bench goes after submode values that are nonzero while the mode bits are 2'b11. A decoder that looks only at the mode bits would wrongly report controller mode for these. It writes legacy enable and pending values while the controller is active and then switches back. A design that lets such writes through, or that zeroes the stored bits instead of masking the view, returns the wrong value after the switch. Returns are issued with previous privilege below, equal to and above the current privilege, so an inverted or non-strict compare leaves a stale threshold or clears it wrongly. Traps are stacked at two levels before legacy mode is entered and left again, which exposes a previous level that survives the mode change or is restored from the wrong slot.

// File: rtl/irqcsr_pkg.sv
package irqcsr_pkg;
  localparam int LVL_W  = 8;
  localparam int PRIV_W = 2;
  localparam int CODE_W = 12;

  localparam logic [2:0] SEL_VEC   = 3'd0;
  localparam logic [2:0] SEL_TBL   = 3'd1;
  localparam logic [2:0] SEL_CAUSE = 3'd2;
  localparam logic [2:0] SEL_STAT  = 3'd3;
  localparam logic [2:0] SEL_IEN   = 3'd4;
  localparam logic [2:0] SEL_IPEND = 3'd5;
  localparam logic [2:0] SEL_ACT   = 3'd6;
  localparam logic [2:0] SEL_THR   = 3'd7;

  localparam int CAUSE_PPRIV_LO = 28;
  localparam int CAUSE_PEN      = 27;
  localparam int CAUSE_PLVL_LO  = 16;
  localparam int STAT_GEN       = 3;
  localparam int STAT_PEN       = 7;
  localparam int STAT_PPRIV_LO  = 11;
  localparam int ALIGN_BITS     = 6;

  localparam logic [PRIV_W-1:0] PRIV_LOWEST = 2'd0;
  localparam logic [LVL_W-1:0]  THR_LOWEST  = '0;
endpackage

// File: rtl/irqcsr_vec_regs.sv
module irqcsr_vec_regs
  import irqcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_vec,
  input  logic            wr_tbl,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] vec_q,
  output logic [XLEN-1:0] tbl_q,
  output logic            ctl_mode,
  output logic            leave_ctl
);
  function automatic logic is_ctl(input logic [XLEN-1:0] v);
    return (v[1:0] == 2'b11) && (v[5:2] == 4'b0000);
  endfunction

  assign ctl_mode  = is_ctl(vec_q);
  assign leave_ctl = wr_vec && is_ctl(vec_q) && !is_ctl(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q <= '0;
      tbl_q <= '0;
    end else begin
      if (wr_vec) vec_q <= wdata;
      if (wr_tbl) tbl_q <= {wdata[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/irqcsr_lvl_regs.sv
module irqcsr_lvl_regs
  import irqcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             leave_ctl,
  input  logic             trap_take,
  input  logic [LVL_W-1:0] trap_level,
  input  logic             ret_restore,
  input  logic             ret_lower,
  input  logic             wr_thr,
  input  logic [LVL_W-1:0] thr_wdata,
  input  logic             wr_plvl,
  input  logic [LVL_W-1:0] plvl_wdata,
  output logic [LVL_W-1:0] act_q,
  output logic [LVL_W-1:0] plvl_q,
  output logic [LVL_W-1:0] thr_q,
  output logic [LVL_W-1:0] eff
);
  assign eff = (act_q > thr_q) ? act_q : thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      plvl_q <= '0;
      thr_q  <= THR_LOWEST;
    end else begin
      if (trap_take)        act_q <= trap_level;
      else if (ret_restore) act_q <= plvl_q;

      if (leave_ctl)      plvl_q <= '0;
      else if (trap_take) plvl_q <= act_q;
      else if (wr_plvl)   plvl_q <= plvl_wdata;

      if (ret_lower)   thr_q <= THR_LOWEST;
      else if (wr_thr) thr_q <= thr_wdata;
    end
  end
endmodule

// File: rtl/irqcsr_legacy_regs.sv
module irqcsr_legacy_regs #(
  parameter int LEG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_mode,
  input  logic             wr_en,
  input  logic             wr_pend,
  input  logic [LEG_W-1:0] wdata,
  output logic [LEG_W-1:0] ien_q,
  output logic [LEG_W-1:0] ipend_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      ipend_q <= '0;
    end else if (!ctl_mode) begin
      if (wr_en)   ien_q   <= wdata;
      if (wr_pend) ipend_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_mode_csr_unit.sv
module irq_mode_csr_unit
  import irqcsr_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LEG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic [1:0]        cur_priv,
  input  logic              trap_valid,
  input  logic              trap_irq,
  input  logic [11:0]       trap_code,
  input  logic [7:0]        trap_level,
  input  logic              ret_valid,
  output logic              ctl_mode,
  output logic [XLEN-1:0]   vec_base,
  output logic [XLEN-1:0]   tbl_base,
  output logic [7:0]        eff_level
);
  localparam int IRQ_BIT = XLEN - 1;

  logic            wr;
  logic            leave_ctl;
  logic [XLEN-1:0] vec_q, tbl_q;
  logic [LVL_W-1:0] act_q, plvl_q, thr_q;
  logic [LEG_W-1:0] ien_q, ipend_q;
  logic             stat_gen, stat_pen;
  logic [PRIV_W-1:0] stat_ppriv;
  logic [CODE_W-1:0] cause_code;
  logic              cause_irq;
  logic [XLEN-1:0]   rd_val;
  logic              ret_lower;

  assign wr        = csr_en && csr_we;
  assign ret_lower = ret_valid && (stat_ppriv < cur_priv);

  irqcsr_vec_regs #(.XLEN(XLEN)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .wr_vec    (wr && csr_sel == SEL_VEC),
    .wr_tbl    (wr && csr_sel == SEL_TBL),
    .wdata     (csr_wdata),
    .vec_q     (vec_q),
    .tbl_q     (tbl_q),
    .ctl_mode  (ctl_mode),
    .leave_ctl (leave_ctl)
  );

  irqcsr_lvl_regs u_lvl (
    .clk         (clk),
    .rst         (rst),
    .leave_ctl   (leave_ctl),
    .trap_take   (trap_valid && trap_irq && ctl_mode),
    .trap_level  (trap_level),
    .ret_restore (ret_valid && ctl_mode),
    .ret_lower   (ret_lower),
    .wr_thr      (wr && csr_sel == SEL_THR),
    .thr_wdata   (csr_wdata[LVL_W-1:0]),
    .wr_plvl     (wr && csr_sel == SEL_CAUSE && ctl_mode),
    .plvl_wdata  (csr_wdata[CAUSE_PLVL_LO +: LVL_W]),
    .act_q       (act_q),
    .plvl_q      (plvl_q),
    .thr_q       (thr_q),
    .eff         (eff_level)
  );

  irqcsr_legacy_regs #(.LEG_W(LEG_W)) u_leg (
    .clk      (clk),
    .rst      (rst),
    .ctl_mode (ctl_mode),
    .wr_en    (wr && csr_sel == SEL_IEN),
    .wr_pend  (wr && csr_sel == SEL_IPEND),
    .wdata    (csr_wdata[LEG_W-1:0]),
    .ien_q    (ien_q),
    .ipend_q  (ipend_q)
  );

  assign vec_base = {vec_q[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign tbl_base = tbl_q;

  // Status fields and cause code/flag: trap, then return, then software write.
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_gen   <= 1'b0;
      stat_pen   <= 1'b0;
      stat_ppriv <= PRIV_LOWEST;
      cause_code <= '0;
      cause_irq  <= 1'b0;
    end else if (trap_valid) begin
      stat_ppriv <= cur_priv;
      stat_pen   <= stat_gen;
      stat_gen   <= 1'b0;
      cause_code <= trap_code;
      cause_irq  <= trap_irq;
    end else if (ret_valid) begin
      stat_gen   <= stat_pen;
      stat_pen   <= 1'b1;
      stat_ppriv <= PRIV_LOWEST;
    end else if (wr && csr_sel == SEL_STAT) begin
      stat_gen   <= csr_wdata[STAT_GEN];
      stat_pen   <= csr_wdata[STAT_PEN];
      stat_ppriv <= csr_wdata[STAT_PPRIV_LO +: PRIV_W];
    end else if (wr && csr_sel == SEL_CAUSE) begin
      cause_code <= csr_wdata[CODE_W-1:0];
      cause_irq  <= csr_wdata[IRQ_BIT];
      if (ctl_mode) begin
        stat_ppriv <= csr_wdata[CAUSE_PPRIV_LO +: PRIV_W];
        stat_pen   <= csr_wdata[CAUSE_PEN];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (csr_sel)
      SEL_VEC:   rd_val = vec_q;
      SEL_TBL:   rd_val = tbl_q;
      SEL_CAUSE: begin
        rd_val[IRQ_BIT]      = cause_irq;
        rd_val[CODE_W-1:0]   = cause_code;
        if (ctl_mode) begin
          rd_val[CAUSE_PPRIV_LO +: PRIV_W] = stat_ppriv;
          rd_val[CAUSE_PEN]                = stat_pen;
          rd_val[CAUSE_PLVL_LO +: LVL_W]   = plvl_q;
        end
      end
      SEL_STAT: begin
        rd_val[STAT_GEN]                = stat_gen;
        rd_val[STAT_PEN]                = stat_pen;
        rd_val[STAT_PPRIV_LO +: PRIV_W] = stat_ppriv;
      end
      SEL_IEN:   if (!ctl_mode) rd_val[LEG_W-1:0] = ien_q;
      SEL_IPEND: if (!ctl_mode) rd_val[LEG_W-1:0] = ipend_q;
      SEL_ACT:   rd_val[LVL_W-1:0] = act_q;
      default:   rd_val[LVL_W-1:0] = thr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_en) csr_rdata <= rd_val;
  end
endmodule

// File: rtl/irqcsr_checker.sv
module irqcsr_checker #(
  parameter int XLEN  = 32,
  parameter int LEG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             csr_en,
  input logic             csr_we,
  input logic [2:0]       csr_sel,
  input logic [XLEN-1:0]  csr_rdata,
  input logic [1:0]       cur_priv,
  input logic             trap_valid,
  input logic             ret_valid,
  input logic             ctl_mode,
  input logic [7:0]       eff_level,
  input logic [7:0]       act_q,
  input logic [7:0]       plvl_q,
  input logic [7:0]       thr_q,
  input logic [LEG_W-1:0] ien_q,
  input logic [1:0]       stat_ppriv,
  input logic             stat_gen
);
  a_r6_eff_is_max: assert property (@(posedge clk) disable iff (rst)
    (eff_level >= act_q) && (eff_level >= thr_q) && ((eff_level == act_q) || (eff_level == thr_q)));

  a_r5_leave_clears_plvl: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_mode) |-> (plvl_q == 8'd0));

  a_r7_ret_lower_thr: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && (stat_ppriv < cur_priv)) |=> (thr_q == 8'd0));

  a_r3_legacy_hidden: assert property (@(posedge clk) disable iff (rst)
    (csr_en && ctl_mode && (csr_sel == 3'd4 || csr_sel == 3'd5)) |=> (csr_rdata == '0));

  a_r3_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_we && ctl_mode && csr_sel == 3'd4) |=> $stable(ien_q));

  a_r2_tbl_low_zero: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_sel == 3'd1) |=> (csr_rdata[5:0] == 6'd0));

  a_r11_act_readonly: assert property (@(posedge clk) disable iff (rst)
    (csr_en && csr_we && csr_sel == 3'd6 && !trap_valid && !ret_valid) |=> $stable(act_q));

  a_r9_trap_clears_gen: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> !stat_gen);
endmodule

bind irq_mode_csr_unit irqcsr_checker #(.XLEN(XLEN), .LEG_W(LEG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .csr_en     (csr_en),
  .csr_we     (csr_we),
  .csr_sel    (csr_sel),
  .csr_rdata  (csr_rdata),
  .cur_priv   (cur_priv),
  .trap_valid (trap_valid),
  .ret_valid  (ret_valid),
  .ctl_mode   (ctl_mode),
  .eff_level  (eff_level),
  .act_q      (act_q),
  .plvl_q     (plvl_q),
  .thr_q      (thr_q),
  .ien_q      (ien_q),
  .stat_ppriv (stat_ppriv),
  .stat_gen   (stat_gen)
);

// File: tb/sim_irq_mode_csr_unit.sv
`timescale 1ns/1ps
module sim_irq_mode_csr_unit;
  localparam int XLEN  = 32;
  localparam int LEG_W = 16;

  logic clk = 0, rst = 1;
  logic csr_en = 0, csr_we = 0;
  logic [2:0] csr_sel = 0;
  logic [XLEN-1:0] csr_wdata = 0, csr_rdata;
  logic [1:0] cur_priv = 2'd3;
  logic trap_valid = 0, trap_irq = 0, ret_valid = 0;
  logic [11:0] trap_code = 0;
  logic [7:0] trap_level = 0;
  logic ctl_mode;
  logic [XLEN-1:0] vec_base, tbl_base;
  logic [7:0] eff_level;

  int checks = 0, fails = 0;

  // model state
  logic [XLEN-1:0] m_vec, m_tbl;
  logic [LEG_W-1:0] m_ien, m_ipend;
  logic m_gen, m_pen, m_irq;
  logic [1:0] m_ppriv;
  logic [11:0] m_code;
  logic [7:0] m_act, m_plvl, m_thr;

  always #5 clk = ~clk;

  irq_mode_csr_unit #(.XLEN(XLEN), .LEG_W(LEG_W)) u0 (
    .clk(clk), .rst(rst), .csr_en(csr_en), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cur_priv(cur_priv),
    .trap_valid(trap_valid), .trap_irq(trap_irq), .trap_code(trap_code),
    .trap_level(trap_level), .ret_valid(ret_valid), .ctl_mode(ctl_mode),
    .vec_base(vec_base), .tbl_base(tbl_base), .eff_level(eff_level));

  function automatic logic f_ctl(input logic [XLEN-1:0] v);
    return (v[1:0] == 2'b11) && (v[5:2] == 4'd0);
  endfunction

  function automatic logic [XLEN-1:0] f_read(input logic [2:0] s);
    logic [XLEN-1:0] r;
    r = '0;
    case (s)
      3'd0: r = m_vec;
      3'd1: r = m_tbl;
      3'd2: begin
        r[XLEN-1] = m_irq; r[11:0] = m_code;
        if (f_ctl(m_vec)) begin r[29:28] = m_ppriv; r[27] = m_pen; r[23:16] = m_plvl; end
      end
      3'd3: begin r[3] = m_gen; r[7] = m_pen; r[12:11] = m_ppriv; end
      3'd4: if (!f_ctl(m_vec)) r[LEG_W-1:0] = m_ien;
      3'd5: if (!f_ctl(m_vec)) r[LEG_W-1:0] = m_ipend;
      3'd6: r[7:0] = m_act;
      default: r[7:0] = m_thr;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_vec = 0; m_tbl = 0; m_ien = 0; m_ipend = 0; m_gen = 0; m_pen = 0; m_irq = 0;
    m_ppriv = 0; m_code = 0; m_act = 0; m_plvl = 0; m_thr = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_sel = s; csr_wdata = d;
    @(posedge clk);
    case (s)
      3'd0: begin if (f_ctl(m_vec) && !f_ctl(d)) m_plvl = 0; m_vec = d; end
      3'd1: m_tbl = {d[XLEN-1:6], 6'd0};
      3'd2: begin
        m_code = d[11:0]; m_irq = d[XLEN-1];
        if (f_ctl(m_vec)) begin m_ppriv = d[29:28]; m_pen = d[27]; m_plvl = d[23:16]; end
      end
      3'd3: begin m_gen = d[3]; m_pen = d[7]; m_ppriv = d[12:11]; end
      3'd4: if (!f_ctl(m_vec)) m_ien = d[LEG_W-1:0];
      3'd5: if (!f_ctl(m_vec)) m_ipend = d[LEG_W-1:0];
      3'd7: m_thr = d[7:0];
      default: ;
    endcase
    #1 csr_en = 0; csr_we = 0;
  endtask

  task automatic rd(input logic [2:0] s, input string req);
    @(negedge clk);
    csr_en = 1; csr_we = 0; csr_sel = s;
    @(negedge clk);
    csr_en = 0;
    check(req, csr_rdata, f_read(s));
  endtask

  task automatic trap(input logic irq, input logic [11:0] code, input logic [7:0] lvl);
    @(negedge clk);
    trap_valid = 1; trap_irq = irq; trap_code = code; trap_level = lvl;
    @(posedge clk);
    if (irq && f_ctl(m_vec)) begin m_plvl = m_act; m_act = lvl; end
    m_code = code; m_irq = irq; m_ppriv = cur_priv; m_pen = m_gen; m_gen = 0;
    #1 trap_valid = 0;
  endtask

  task automatic ret();
    @(negedge clk);
    ret_valid = 1;
    @(posedge clk);
    if (m_ppriv < cur_priv) m_thr = 0;
    if (f_ctl(m_vec)) m_act = m_plvl;
    m_gen = m_pen; m_pen = 1; m_ppriv = 0;
    #1 ret_valid = 0;
  endtask

  task automatic chk_eff(input string req);
    @(negedge clk);
    check(req, {24'd0, eff_level}, {24'd0, (m_act > m_thr) ? m_act : m_thr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240929));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R8 reset state
    for (int s = 0; s < 8; s++) rd(3'(s), "R8 reset read");
    check("R8 reset mode", {31'd0, ctl_mode}, '0);
    check("R8 reset eff", {24'd0, eff_level}, '0);

    // R1 decode and base
    wr(3'd0, 32'h0000_1043);
    @(negedge clk);
    check("R1 ctl decode", {31'd0, ctl_mode}, 32'd1);
    check("R1 vec base", vec_base, 32'h0000_1040);
    rd(3'd0, "R1 readback");
    wr(3'd0, 32'h0000_1013);
    @(negedge clk);
    check("R1 submode nonzero", {31'd0, ctl_mode}, 32'd0);
    wr(3'd0, 32'h0000_1001);
    @(negedge clk);
    check("R1 mode 01", {31'd0, ctl_mode}, 32'd0);

    // R2 table base
    wr(3'd1, 32'hDEAD_BEFF);
    rd(3'd1, "R2 tbl low zero");
    @(negedge clk);
    check("R2 tbl port", tbl_base, 32'hDEAD_BEC0);

    // R3 legacy hidden and kept
    wr(3'd4, 32'h0000_ABCD);
    wr(3'd5, 32'h0000_1357);
    wr(3'd0, 32'h0000_2003);
    rd(3'd4, "R3 enable hidden");
    rd(3'd5, "R3 pending hidden");
    wr(3'd4, 32'h0000_1234);
    wr(3'd5, 32'h0000_FFFF);
    wr(3'd0, 32'h0000_2000);
    rd(3'd4, "R3 enable kept");
    rd(3'd5, "R3 pending kept");

    // R4 mirror
    wr(3'd3, 32'h0000_1088);
    rd(3'd2, "R4 legacy cause hides mirror");
    wr(3'd0, 32'h0000_2003);
    rd(3'd2, "R4 ctl mirror");
    wr(3'd2, 32'h1800_0005);
    rd(3'd3, "R4 cause writes status");

    // R9 R5 R10 stacking and leave
    cur_priv = 2'd3;
    trap(1'b1, 12'h011, 8'd5);
    chk_eff("R9 eff after trap");
    rd(3'd2, "R9 cause after trap");
    trap(1'b1, 12'h022, 8'd9);
    rd(3'd2, "R9 plvl stacked");
    rd(3'd6, "R9 act");
    ret();
    rd(3'd6, "R10 act restored");
    rd(3'd3, "R10 status after ret");
    trap(1'b1, 12'h033, 8'd12);
    wr(3'd0, 32'h0000_2000);
    wr(3'd0, 32'h0000_2003);
    rd(3'd2, "R5 plvl cleared");
    wr(3'd2, 32'h0000_0000);
    wr(3'd0, 32'h0000_2000);
    wr(3'd2, 32'h00AB_0000);
    wr(3'd0, 32'h0000_2003);
    rd(3'd2, "R5 legacy plvl write ignored");

    // R6 R7 threshold
    wr(3'd7, 32'h0000_00FE);
    rd(3'd7, "R6 thr readback");
    chk_eff("R6 eff thr");
    wr(3'd3, 32'h0000_0000);
    cur_priv = 2'd3;
    ret();
    rd(3'd7, "R7 lower clears thr");
    wr(3'd7, 32'h0000_0007);
    wr(3'd3, 32'h0000_1800);
    ret();
    rd(3'd7, "R7 same priv keeps thr");
    wr(3'd3, 32'h0000_1800);
    cur_priv = 2'd1;
    ret();
    rd(3'd7, "R7 raise keeps thr");

    // R11 active level read-only
    wr(3'd6, 32'h0000_0077);
    rd(3'd6, "R11 act read-only");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [2:0] s;
      logic [XLEN-1:0] d;
      op = $urandom_range(0, 9);
      s = 3'($urandom_range(0, 7));
      d = $urandom;
      case ($urandom_range(0, 2))
        0: cur_priv = 2'd0;
        1: cur_priv = 2'd1;
        default: cur_priv = 2'd3;
      endcase
      if (s == 3'd0 && d[0]) d[5:0] = 6'b000011;
      if (op < 5) wr(s, d);
      else if (op < 7) trap(d[31], d[11:0], d[19:12]);
      else if (op < 8) ret();
      rd(3'($urandom_range(0, 7)), "R4 R9 R10 random read");
      chk_eff("R6 random eff");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule